// File: doc/BRIEF.md
# Pipelined Converter Stage Alignment and Overlap Correction

This block is the digital back end of a multi-stage subranging converter. Each analog stage resolves a coarse code for a sample, and each later stage delivers its code one clock after the stage before it. The block puts every stage code through its own delay line. The delays shrink by one per stage, so all codes of one sample reach the correction logic in the same cycle.

The first stage carries plain binary weight. Every later stage has one redundant bit, which lets the residue stray from its ideal value without losing codes. The correction step shifts the running word left by the non-redundant width of a later stage and adds that stage's code minus half of its ideal span. The result is clamped to the output range, and an overflow flag marks each clamp. A valid flag travels with the first-stage code, so a sample's output appears after a fixed latency.

With the default parameters there are two stages: a 3-bit first stage and a 4-bit second stage. The output word is 6 bits, formed as first*8 + second - 4 and clamped to 0..63. The latency is two clock cycles from the first-stage code to the registered output.

Top module: `pipe_adc_align_correct`

## Requirements
- R1: While reset is held and after it is released, `valid_o`, `ovf_o` and `code_o` are all 0 until the first sample completes.
- R2: The stage-k code of a sample is taken k cycles after that sample's first-stage code. With the defaults, the second-stage code is taken one cycle after the first-stage code.
- R3: `valid_o` rises exactly TOTAL_LAT cycles after `valid_i`, where TOTAL_LAT = NUM_STAGES + EXTRA_DELAY. With the defaults this is 2 cycles.
- R4: For two stages, the corrected word equals first*8 + second - 4 whenever that value lies in 0..63. The first stage occupies `first_code_i[2:0]` and the second stage occupies `later_code_i[3:0]`.
- R5: A sum below 0 gives `code_o` = 0, and a sum above 63 gives `code_o` = 63.
- R6: `ovf_o` is 1 exactly in the cycles where `valid_o` is 1 and the sample was clamped. In all other cycles it is 0.
- R7: `code_o` keeps its last value in cycles without a completed sample. Stage codes presented in cycles that belong to no valid sample have no effect.
- R8: Samples presented on consecutive cycles each give their own output on consecutive cycles. No sample is lost or merged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Marks a new sample's first-stage code |
| first_code_i | input | FIRST_W | Coarse code of the first stage |
| later_code_i | input | (NUM_STAGES-1)*LATER_W | Codes of the later stages; stage k is in slot k-1 (LSB first) |
| valid_o | output | 1 | Corrected word for one sample is present |
| code_o | output | OUT_W | Corrected, clamped output word |
| ovf_o | output | 1 | Output was clamped |

## Verification
The cycle of interest carries two samples at once. The second-stage code of sample n enters in the same cycle as the first-stage code of sample n+1, while an earlier sample that was clamped is being registered at the output. The bench drives runs of back-to-back samples in which rail sums (0,0 and 7,15) alternate with in-range pairs, and surrounds them with idle cycles whose stage inputs are random garbage. An independent bench function computes each expected word and flag, and the bench checks the results against it two cycles later. It also checks that the held output is unchanged through every idle gap.

// File: rtl/pipe_adc_pkg.sv
package pipe_adc_pkg;

   // Output width from stage widths: first stage full weight,
   // each later stage contributes its width minus one redundant bit.
   function automatic int calc_out_w(input int first_w, input int later_w,
                                     input int stages);
      return first_w + (stages - 1) * (later_w - 1);
   endfunction

   // Half of the ideal span of a later stage, removed on merge.
   function automatic int calc_offset(input int later_w);
      return 1 << (later_w - 2);
   endfunction

endpackage

// File: rtl/stage_delay.sv
module stage_delay #(
   parameter int W     = 4,
   parameter int DEPTH = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (W < 1) begin : g_bad_w
         $error("stage_delay: W must be at least 1");
      end
      if (DEPTH < 0) begin : g_bad_depth
         $error("stage_delay: DEPTH must not be negative");
      end

      if (DEPTH == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] pipe [DEPTH];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) pipe[i] <= '0;
            end else begin
               pipe[0] <= d;
               for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
            end
         end
         assign q = pipe[DEPTH-1];
      end
   endgenerate

endmodule

// File: rtl/overlap_correct.sv
module overlap_correct
   import pipe_adc_pkg::*;
#(
   parameter int NUM_STAGES = 2,
   parameter int FIRST_W    = 3,
   parameter int LATER_W    = 4,
   localparam int OUT_W     = calc_out_w(FIRST_W, LATER_W, NUM_STAGES),
   localparam int LW_ALL    = (NUM_STAGES - 1) * LATER_W
) (
   input  logic [FIRST_W-1:0] first_code,
   input  logic [LW_ALL-1:0]  later_code,
   output logic [OUT_W-1:0]   word,
   output logic               clamped
);

   localparam int ACC_W = OUT_W + 3;
   localparam int SHIFT = LATER_W - 1;
   localparam logic signed [ACC_W-1:0] OFS  = ACC_W'(calc_offset(LATER_W));
   localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((1 << OUT_W) - 1);

   logic signed [ACC_W-1:0] acc;

   always_comb begin
      acc = '0;
      acc[FIRST_W-1:0] = first_code;
      for (int s = 0; s < NUM_STAGES - 1; s++) begin
         acc = (acc <<< SHIFT)
             + $signed(ACC_W'(later_code[s*LATER_W +: LATER_W]))
             - OFS;
      end
   end

   always_comb begin
      if (acc < 0) begin
         word    = '0;
         clamped = 1'b1;
      end else if (acc > MAXV) begin
         word    = '1;
         clamped = 1'b1;
      end else begin
         word    = acc[OUT_W-1:0];
         clamped = 1'b0;
      end
   end

endmodule

// File: rtl/pipe_adc_align_correct.sv
module pipe_adc_align_correct
   import pipe_adc_pkg::*;
#(
   parameter int NUM_STAGES  = 2,
   parameter int FIRST_W     = 3,
   parameter int LATER_W     = 4,
   parameter int EXTRA_DELAY = 0,
   localparam int OUT_W      = calc_out_w(FIRST_W, LATER_W, NUM_STAGES),
   localparam int LW_ALL     = (NUM_STAGES - 1) * LATER_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               valid_i,
   input  logic [FIRST_W-1:0] first_code_i,
   input  logic [LW_ALL-1:0]  later_code_i,
   output logic               valid_o,
   output logic [OUT_W-1:0]   code_o,
   output logic               ovf_o
);

   localparam int HEAD_DEPTH = EXTRA_DELAY + NUM_STAGES - 1;
   localparam int TOTAL_LAT  = HEAD_DEPTH + 1;
   localparam int CNT_W      = $clog2(TOTAL_LAT + 2) + 1;

   generate
      if (NUM_STAGES < 2) begin : g_bad_stages
         $error("pipe_adc_align_correct: NUM_STAGES must be at least 2");
      end
      if (LATER_W < 2) begin : g_bad_later
         $error("pipe_adc_align_correct: LATER_W must be at least 2");
      end
      if (FIRST_W < 1) begin : g_bad_first
         $error("pipe_adc_align_correct: FIRST_W must be at least 1");
      end
      if (OUT_W > 28) begin : g_bad_out
         $error("pipe_adc_align_correct: output word too wide");
      end
      if (EXTRA_DELAY < 0) begin : g_bad_extra
         $error("pipe_adc_align_correct: EXTRA_DELAY must not be negative");
      end
   endgenerate

   // First stage and valid flag travel together through the longest line.
   logic [FIRST_W:0]    head_q;
   logic                al_valid;
   logic [FIRST_W-1:0]  al_first;
   logic [LW_ALL-1:0]   al_later;

   stage_delay #(.W(FIRST_W + 1), .DEPTH(HEAD_DEPTH)) u_head (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({valid_i, first_code_i}),
      .q     (head_q)
   );
   assign al_valid = head_q[FIRST_W];
   assign al_first = head_q[FIRST_W-1:0];

   // Later stage k arrives k cycles late, so it needs k fewer delays.
   generate
      for (genvar k = 1; k < NUM_STAGES; k++) begin : g_later
         stage_delay #(.W(LATER_W), .DEPTH(HEAD_DEPTH - k)) u_dly (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (later_code_i[(k-1)*LATER_W +: LATER_W]),
            .q     (al_later[(k-1)*LATER_W +: LATER_W])
         );
      end
   endgenerate

   logic [OUT_W-1:0] corr_word;
   logic             corr_clamp;

   overlap_correct #(
      .NUM_STAGES (NUM_STAGES),
      .FIRST_W    (FIRST_W),
      .LATER_W    (LATER_W)
   ) u_corr (
      .first_code (al_first),
      .later_code (al_later),
      .word       (corr_word),
      .clamped    (corr_clamp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         ovf_o   <= 1'b0;
         code_o  <= '0;
      end else begin
         valid_o <= al_valid;
         ovf_o   <= al_valid & corr_clamp;
         if (al_valid) code_o <= corr_word;
      end
   end

   // Samples in flight: accepted at the input, not yet delivered.
   logic [CNT_W-1:0] inflight;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) inflight <= '0;
      else        inflight <= inflight + CNT_W'(valid_i) - CNT_W'(valid_o);
   end

   // R3 R8: no sample is lost or held longer than the fixed latency
   assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
      inflight <= CNT_W'(TOTAL_LAT));

   // R5: a clamped output sits on a rail
   assert_clamp_rail_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && ovf_o) |-> (code_o == '0 || code_o == '1));

   // R6: overflow never reported without a sample
   assert_flag_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> !ovf_o);

   // R7: output word holds through cycles without an aligned sample
   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !al_valid |=> $stable(code_o));

endmodule

// File: tb/tb_pipe_adc_align_correct.sv
`timescale 1ns/1ps
module tb_pipe_adc_align_correct;

   localparam int N = 3000;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       valid_i;
   logic [2:0] first_code_i;
   logic [3:0] later_code_i;
   logic       valid_o;
   logic [5:0] code_o;
   logic       ovf_o;

   always #5 clk = ~clk;

   pipe_adc_align_correct dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .valid_i      (valid_i),
      .first_code_i (first_code_i),
      .later_code_i (later_code_i),
      .valid_o      (valid_o),
      .code_o       (code_o),
      .ovf_o        (ovf_o)
   );

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   logic       sv [N];
   logic [2:0] s0 [N];
   logic [3:0] s1 [N];

   function automatic int raw_sum(input int a, input int b);
      return a * 8 + b - 4;
   endfunction

   function automatic int clamp63(input int x);
      if (x < 0)  return 0;
      if (x > 63) return 63;
      return x;
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   initial begin : watchdog
      #(200000 * 10);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      int last_code;
      int n_in;
      int n_out;
      int pairs [12][2];
      last_code = 0;
      n_in = 0;
      n_out = 0;

      // Directed corners, back-to-back (R8), rails alternating with in-range
      pairs = '{'{0,0}, '{7,15}, '{7,11}, '{0,4}, '{3,12}, '{0,3},
                '{7,12}, '{0,0}, '{5,0}, '{2,7}, '{7,15}, '{1,4}};
      for (int i = 0; i < N; i++) begin
         sv[i] = 1'b0; s0[i] = 3'($urandom); s1[i] = 4'($urandom);
      end
      void'($urandom(32'h5eed_1234));
      for (int i = 0; i < 12; i++) begin
         sv[i] = 1'b1; s0[i] = 3'(pairs[i][0]); s1[i] = 4'(pairs[i][1]);
      end
      for (int i = 14; i < N; i++) begin
         sv[i] = ($urandom % 4) != 0;
         s0[i] = 3'($urandom);
         case ($urandom % 6)
            0: s1[i] = 4'($urandom % 4);
            1: s1[i] = 4'(12 + $urandom % 4);
            default: s1[i] = 4'($urandom);
         endcase
      end

      rst_n = 1'b0; valid_i = 1'b0; first_code_i = '0; later_code_i = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 valid_o in reset", int'(valid_o), 0);
      check("R1 code_o in reset", int'(code_o), 0);
      check("R1 ovf_o in reset", int'(ovf_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 valid_o after release", int'(valid_o), 0);

      for (int c = 0; c < N + 3; c++) begin
         @(negedge clk);
         if (valid_o) n_out++;
         if (c >= 2) begin : chk
            int k;
            int r;
            k = c - 2;
            // R2 R3: stage codes aligned, valid arrives two cycles later
            check("R3 valid_o latency", int'(valid_o), int'(sv[k]));
            if (sv[k]) begin
               r = raw_sum(int'(s0[k]), int'(s1[k]));
               last_code = clamp63(r);
               if (r < 0 || r > 63) begin
                  check("R5 clamped code_o", int'(code_o), last_code);
                  check("R6 ovf_o on clamp", int'(ovf_o), 1);
               end else begin
                  check("R4 corrected code_o", int'(code_o), last_code);
                  check("R6 ovf_o no clamp", int'(ovf_o), 0);
               end
            end else begin
               check("R7 code_o held", int'(code_o), last_code);
               check("R6 ovf_o idle", int'(ovf_o), 0);
            end
         end
         if (c < N) begin
            valid_i      = sv[c];
            first_code_i = s0[c];
            if (sv[c]) n_in++;
         end else begin
            valid_i      = 1'b0;
            first_code_i = 3'($urandom);
         end
         // R2: second-stage code of the previous cycle's sample
         if (c >= 1 && c - 1 < N) later_code_i = s1[c-1];
         else                     later_code_i = 4'($urandom);
      end
      @(negedge clk);
      if (valid_o) n_out++;
      check("R8 outputs equal inputs", n_out, n_in);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule